// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block produces the instruction fetch address for a small microcontroller core. The program counter is 10 bits wide and covers two pages of 512 words. On every instruction cycle the core hands the block a decoded control class. The block then picks the next address from one of five sources: the sequential increment, an absolute jump target, a subroutine call target, a computed write to the low address byte, or an address popped from a two-entry return stack.

Jump, call and computed targets take their top address bit from the page-select bit of the core's status register. Calls and computed writes also force address bit 8 to zero, so they can only reach the lower 256 words of a page. A return raises a flag that tells the core to load the instruction's literal into its working register. When the return stack runs dry it keeps handing out its deepest entry, and pushing past two levels discards the oldest address.

There is no data stream at this block's edge. Every pin is a plain control or status signal, and there is no back-pressure. The instruction-cycle enable is the only pacing input.

Top module: `pgpc_sequencer`

## Requirements
- R1: While reset is asserted, and on leaving reset, the PC is 0x3FF (all ones) and both return-stack levels are zero. A return taken as the first instruction therefore yields PC 0x000.
- R2: With class 0 (sequential) and the enable high, the PC goes up by one at the next clock edge. The step after 0x3FF gives 0x000.
- R3: While the enable is low, the PC and both stack levels keep their values and the return flag stays low, whatever the class.
- R4: With class 1 (jump), the next PC is {page_sel, imm[8:0]}: bit 9 is page_sel and bits 8:0 come from the immediate.
- R5: With class 2 (call), the next PC is {page_sel, 1'b0, imm[7:0]}.
- R6: With class 3 (low-byte write), the next PC is {page_sel, 1'b0, low_val[7:0]}.
- R7: A call moves level 1 into level 2 and stores the current PC plus one into level 1. The PC plus one wraps at 10 bits and is zero-extended to 12 bits. Only the two most recent return addresses are kept.
- R8: With class 4 (return), the next PC is bits 9:0 of level 1, level 1 takes the value of level 2, and level 2 does not change. Repeated returns therefore keep producing the old level-2 address.
- R9: The return flag w_lit_load is high exactly when the enable is high and the class is 4.
- R10: Class codes 5, 6 and 7 behave like class 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cyc_en | input | 1 | Instruction-cycle enable |
| ctl | input | 3 | Decoded control class (0 sequential, 1 jump, 2 call, 3 low-byte write, 4 return) |
| imm | input | 9 | Immediate field of the instruction |
| low_val | input | 8 | Value written to the low PC byte |
| page_sel | input | 1 | Page-select bit from the status register |
| pc_o | output | 10 | Current program counter |
| w_lit_load | output | 1 | Load the return literal into W |

## Verification
The bench drives a jump to 0x3FF and then steps once. A design with a wider counter, or one that saturates, would give 0x400 or 0x3FF where 0x000 is expected.

It nests three calls and then returns three times. A stack that popped in zeros, or kept the oldest address instead of the newest, would send the later returns to the wrong place.

It issues a call with the enable low and then returns at once. A design that pushed while disabled would return to 0x001 instead of 0x000.

It also drives calls and low-byte writes with imm[8] set and page_sel high. A design that took bit 8 from the immediate, or dropped the page bit, would land 256 or 512 words away from the expected target.

// File: rtl/pgpc_pkg.sv
package pgpc_pkg;
  typedef enum logic [2:0] {
    CLS_SEQ  = 3'd0,
    CLS_JMP  = 3'd1,
    CLS_CALL = 3'd2,
    CLS_WLOW = 3'd3,
    CLS_RET  = 3'd4
  } pc_cls_e;
endpackage

// File: rtl/pgpc_target.sv
module pgpc_target
  import pgpc_pkg::*;
#(
  parameter int PC_W = 10
) (
  input  logic [PC_W-1:0] cur_pc,
  input  logic [2:0]      cls,
  input  logic [PC_W-2:0] imm,
  input  logic [PC_W-3:0] low_val,
  input  logic            page_sel,
  input  logic [PC_W-1:0] ret_pc,
  output logic [PC_W-1:0] nxt_pc,
  output logic [PC_W-1:0] seq_pc
);
  localparam int LOW_W = PC_W - 2;

  always_comb begin
    seq_pc = cur_pc + PC_W'(1);
    case (cls)
      CLS_JMP:  nxt_pc = {page_sel, imm};
      CLS_CALL: nxt_pc = {page_sel, 1'b0, imm[LOW_W-1:0]};
      CLS_WLOW: nxt_pc = {page_sel, 1'b0, low_val};
      CLS_RET:  nxt_pc = ret_pc;
      default:  nxt_pc = seq_pc;
    endcase
  end
endmodule

// File: rtl/pgpc_retstack.sv
module pgpc_retstack #(
  parameter int PC_W   = 10,
  parameter int ENT_W  = 12,
  parameter int LEVELS = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic [PC_W-1:0]              push_pc,
  output logic [LEVELS-1:0][ENT_W-1:0] lvl
);
  localparam int PAD_W = ENT_W - PC_W;

  logic [ENT_W-1:0] push_ent;
  assign push_ent = {{PAD_W{1'b0}}, push_pc};

  for (genvar i = 0; i < LEVELS; i++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl[i] <= '0;
      end else if (push) begin
        if (i == 0) lvl[i] <= push_ent;
        else        lvl[i] <= lvl[(i == 0) ? 0 : i-1];
      end else if (pop) begin
        if (i == LEVELS-1) lvl[i] <= lvl[i];
        else               lvl[i] <= lvl[(i == LEVELS-1) ? i : i+1];
      end
    end
  end
endmodule

// File: rtl/pgpc_sequencer.sv
module pgpc_sequencer
  import pgpc_pkg::*;
#(
  parameter int PC_W   = 10,
  parameter int ENT_W  = 12,
  parameter int LEVELS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_en,
  input  logic [2:0]      ctl,
  input  logic [PC_W-2:0] imm,
  input  logic [PC_W-3:0] low_val,
  input  logic            page_sel,
  output logic [PC_W-1:0] pc_o,
  output logic            w_lit_load
);
  logic [PC_W-1:0]              pc_q;
  logic [PC_W-1:0]              pc_nxt;
  logic [PC_W-1:0]              pc_inc;
  logic [LEVELS-1:0][ENT_W-1:0] stk_lvl;
  logic [ENT_W-1:0]             stk_top;
  logic                         do_push;
  logic                         do_pop;

  assign do_push = cyc_en && (ctl == CLS_CALL);
  assign do_pop  = cyc_en && (ctl == CLS_RET);
  assign stk_top = stk_lvl[0];

  pgpc_target #(.PC_W(PC_W)) u_tgt (
    .cur_pc   (pc_q),
    .cls      (ctl),
    .imm      (imm),
    .low_val  (low_val),
    .page_sel (page_sel),
    .ret_pc   (stk_top[PC_W-1:0]),
    .nxt_pc   (pc_nxt),
    .seq_pc   (pc_inc)
  );

  pgpc_retstack #(.PC_W(PC_W), .ENT_W(ENT_W), .LEVELS(LEVELS)) u_stk (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (do_push),
    .pop     (do_pop),
    .push_pc (pc_inc),
    .lvl     (stk_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_q <= '1;
    else if (cyc_en) pc_q <= pc_nxt;
  end

  assign pc_o       = pc_q;
  assign w_lit_load = do_pop;
endmodule

// File: rtl/pgpc_chk.sv
module pgpc_chk #(
  parameter int PC_W  = 10,
  parameter int ENT_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cyc_en,
  input logic [2:0]      ctl,
  input logic [PC_W-2:0] imm,
  input logic [PC_W-3:0] low_val,
  input logic            page_sel,
  input logic [PC_W-1:0] pc_o,
  input logic            w_lit_load,
  input logic [ENT_W-1:0] lvl_top,
  input logic [ENT_W-1:0] lvl_next
);
  localparam int PAD_W = ENT_W - PC_W;

  // R1
  reset_exit_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (pc_o == '1 && lvl_top == '0 && lvl_next == '0));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && ctl == 3'd0) |=> pc_o == $past(pc_o) + PC_W'(1));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |=> ($stable(pc_o) && $stable(lvl_top) && $stable(lvl_next)));

  // R4
  jump_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && ctl == 3'd1) |=> pc_o == {$past(page_sel), $past(imm)});

  // R6
  low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && ctl == 3'd3) |=> pc_o == {$past(page_sel), 1'b0, $past(low_val)});

  // R7
  push_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && ctl == 3'd2) |=>
      (lvl_next == $past(lvl_top) &&
       lvl_top == {{PAD_W{1'b0}}, PC_W'($past(pc_o) + PC_W'(1))} &&
       pc_o[PC_W-2] == 1'b0));

  // R8
  pop_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && ctl == 3'd4) |=>
      (pc_o == $past(lvl_top[PC_W-1:0]) && lvl_top == $past(lvl_next) && $stable(lvl_next)));

  // R9
  wflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_lit_load |-> (cyc_en && ctl == 3'd4));
endmodule

bind pgpc_sequencer pgpc_chk #(.PC_W(PC_W), .ENT_W(ENT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cyc_en     (cyc_en),
  .ctl        (ctl),
  .imm        (imm),
  .low_val    (low_val),
  .page_sel   (page_sel),
  .pc_o       (pc_o),
  .w_lit_load (w_lit_load),
  .lvl_top    (stk_lvl[0]),
  .lvl_next   (stk_lvl[1])
);

// File: tb/sim_pgpc_sequencer.sv
module sim_pgpc_sequencer;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b0;
  logic [2:0] ctl = 3'd0;
  logic [8:0] imm = '0;
  logic [7:0] low_val = '0;
  logic       page_sel = 1'b0;
  logic [9:0] pc_o;
  logic       w_lit_load;

  typedef struct {
    logic [9:0] pc;
    logic       w;
    string      pc_tag;
    string      w_tag;
  } exp_t;

  exp_t       q[$];
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 0;
  logic [9:0] m_pc = 10'h3FF;
  logic [11:0] m_l1 = '0;
  logic [11:0] m_l2 = '0;
  string      last_tag = "R1 reset value";

  always #(CLK_P/2) clk = ~clk;

  pgpc_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ctl(ctl), .imm(imm),
    .low_val(low_val), .page_sel(page_sel), .pc_o(pc_o), .w_lit_load(w_lit_load)
  );

  task automatic step(input logic en, input logic [2:0] c, input logic [8:0] im,
                      input logic [7:0] lv, input logic pg, input string tag);
    exp_t e;
    logic [9:0] inc;
    @(posedge clk); #1;
    cyc_en = en; ctl = c; imm = im; low_val = lv; page_sel = pg;
    e.pc = m_pc; e.w = en && (c == 3'd4); e.pc_tag = last_tag; e.w_tag = tag;
    q.push_back(e);
    inc = m_pc + 10'd1;
    if (en) begin
      case (c)
        3'd1: m_pc = {pg, im};
        3'd2: begin m_l2 = m_l1; m_l1 = {2'b00, inc}; m_pc = {pg, 1'b0, im[7:0]}; end
        3'd3: m_pc = {pg, 1'b0, lv};
        3'd4: begin m_pc = m_l1[9:0]; m_l1 = m_l2; end
        default: m_pc = inc;
      endcase
    end
    last_tag = tag;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        n_chk++;
        if (pc_o !== e.pc) begin
          n_err++;
          $display("FAIL %s: pc actual=%h expected=%h", e.pc_tag, pc_o, e.pc);
        end
        n_chk++;
        if (w_lit_load !== e.w) begin
          n_err++;
          $display("FAIL %s: w_lit_load actual=%b expected=%b", e.w_tag, w_lit_load, e.w);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_P * 5000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(1, 3'd4, 9'h000, 8'h00, 0, "R1 R8 R9 first return gives zero");
    step(1, 3'd0, 9'h000, 8'h00, 0, "R2 increment");
    step(1, 3'd0, 9'h000, 8'h00, 1, "R2 increment");
    step(1, 3'd1, 9'h1FF, 8'h00, 1, "R4 jump page 1");
    step(1, 3'd0, 9'h000, 8'h00, 0, "R2 wrap to zero");
    step(0, 3'd2, 9'h055, 8'h00, 1, "R3 disabled call");
    step(1, 3'd4, 9'h000, 8'h00, 0, "R3 R8 stack untouched by disabled call");
    step(0, 3'd4, 9'h000, 8'h00, 0, "R3 R9 disabled return no flag");
    step(1, 3'd1, 9'h1A5, 8'h00, 0, "R4 jump page 0");
    step(1, 3'd2, 9'h1F3, 8'h00, 1, "R5 R7 call bit8 forced low");
    step(1, 3'd3, 9'h1FF, 8'hC7, 0, "R6 low write page 0");
    step(1, 3'd3, 9'h000, 8'h3C, 1, "R6 low write page 1");
    step(1, 3'd6, 9'h0AA, 8'h11, 1, "R10 code 6 increments");
    step(1, 3'd2, 9'h010, 8'h00, 0, "R7 second nested call");
    step(1, 3'd2, 9'h180, 8'h00, 1, "R7 third call drops oldest");
    step(1, 3'd4, 9'h000, 8'h00, 0, "R8 R9 pop level 1");
    step(1, 3'd4, 9'h000, 8'h00, 1, "R8 pop level 2 copy");
    step(1, 3'd4, 9'h000, 8'h00, 0, "R8 underflow repeats level 2");
    step(1, 3'd7, 9'h000, 8'h00, 0, "R10 code 7 increments");
    step(1, 3'd5, 9'h000, 8'h00, 0, "R10 code 5 increments");
    step(0, 3'd1, 9'h0FF, 8'h00, 1, "R3 disabled jump");
    step(0, 3'd0, 9'h000, 8'h00, 0, "R3 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule